// File: doc/BRIEF.md
# Write-Once Flash Timing Tick Divider

This block paces program and erase operations in a flash controller. It turns the oscillator clock into a slow timing tick that later stages use as a clock enable. Software configures it through one byte-wide register on a simple bus. The bus has an address, a write strobe, write data and registered read data. The register holds:

- an optional fixed divide-by-8 prescaler select;
- a 6-bit divide value;
- a read-only flag that shows the register has been configured.

The configuration bits can be written only once after reset. Every later write is dropped until the next reset, so a running timebase cannot be changed by a stray store. Until the first write, the counters stay at zero and no tick is issued. The write that configures the block also starts counting, so the first tick comes exactly one full period after that write.

The output is a one-cycle enable in the oscillator domain, not a derived clock. Choosing a ratio that gives a legal tick frequency is up to software.

Top module: `flash_tick_div`

## Requirements
- R1: After a synchronous reset, all register bits are zero. The bus reads 0x00, `cfg_done` is low, and `tick` stays low.
- R2: The first write to address `REG_ADDR` after reset does two things. It stores write-data bits 6..0, and it sets the configured flag, which is register bit 7 and is also output as `cfg_done`.
- R3: Register bit 7 is read-only: write-data bit 7 has no effect. A read of `REG_ADDR` returns {flag, bits 6..0} one cycle after the address is presented. A write to any other address changes nothing, and a read of any other address returns 0x00.
- R4: After the block is configured, every further write is ignored until the next reset. The stored bits and the tick schedule do not change.
- R5: When bit 6 is 0, the divide ratio N is (bits 5..0) + 1, which ranges from 1 to 64.
- R6: When bit 6 is 1, the ratio is 8 × ((bits 5..0) + 1). The largest ratio is 512, reached with 0x7F.
- R7: `tick` is high for one cycle in every N cycles, and only while the block is configured. If the configuring write is taken at clock edge E, `tick` rises after edge E+N, then after E+2N, and so on.
- R8: A reset after configuration stops the tick and clears the flag. The next write is then accepted as a new first write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| tick | output | 1 | One-cycle timing enable |
| cfg_done | output | 1 | Configured flag (register bit 7) |

## Verification
Two cases are hard to reach from the ports.

The first is a write that arrives while the tick schedule is running. It must leave both the readback and the tick spacing untouched. To create it, the stimulus sends a second write with a different ratio and bit 6 flipped partway through a scoreboard window, while the expected tick times are already queued.

The second is the 512-cycle ratio, where the prescaler wrap and the divider terminal count line up. It is reached with the all-ones write. Each configuration is followed by a reset, so every ratio is measured from its own first write.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  localparam int DIV_W = 6;
  localparam int REG_W = DIV_W + 2;

  typedef struct packed {
    logic             pre_on;
    logic [DIV_W-1:0] div_m1;
  } fdiv_cfg_t;
endpackage

// File: rtl/fdiv_cfg_reg.sv
module fdiv_cfg_reg
  import fdiv_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int REG_ADDR = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output fdiv_cfg_t         cfg,
  output logic              loaded
);
  logic      hit;
  logic      take;
  fdiv_cfg_t cfg_q;
  logic      loaded_q;
  logic [REG_W-1:0] rdata_q;

  assign hit  = (bus_addr == ADDR_W'(REG_ADDR));
  assign take = hit && bus_wr && !loaded_q;

  // Configuration bits and flag: accepted once, frozen until reset
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '0;
      loaded_q <= 1'b0;
    end else if (take) begin
      cfg_q    <= fdiv_cfg_t'(bus_wdata[REG_W-2:0]);
      loaded_q <= 1'b1;
    end
  end

  // Registered read port
  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= hit ? {loaded_q, cfg_q} : '0;
  end

  assign cfg       = cfg_q;
  assign loaded    = loaded_q;
  assign bus_rdata = rdata_q;
endmodule

// File: rtl/fdiv_prescale.sv
module fdiv_prescale #(
  parameter int PRE_LOG2 = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic pre_on,
  output logic pre_en
);
  generate
    if (PRE_LOG2 == 0) begin : g_none
      assign pre_en = run;
    end else begin : g_cnt
      logic [PRE_LOG2-1:0] pc_q;
      always_ff @(posedge clk) begin
        if (rst || !run || !pre_on) pc_q <= '0;
        else                        pc_q <= pc_q + 1'b1;
      end
      assign pre_en = run && (!pre_on || (pc_q == '1));
    end
  endgenerate
endmodule

// File: rtl/fdiv_counter.sv
module fdiv_counter #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic         tick
);
  logic [W-1:0] cnt_q;
  logic         tick_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= 1'b0;
      if (step) begin
        if (cnt_q == limit) begin
          cnt_q  <= '0;
          tick_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign tick = tick_q;
endmodule

// File: rtl/flash_tick_div.sv
module flash_tick_div
  import fdiv_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int REG_ADDR = 3,
  parameter int PRE_LOG2 = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              tick,
  output logic              cfg_done
);
  fdiv_cfg_t cfg_w;
  logic      loaded_w;
  logic      pre_en_w;

  fdiv_cfg_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_reg (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cfg       (cfg_w),
    .loaded    (loaded_w)
  );

  fdiv_prescale #(.PRE_LOG2(PRE_LOG2)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .run    (loaded_w),
    .pre_on (cfg_w.pre_on),
    .pre_en (pre_en_w)
  );

  fdiv_counter #(.W(DIV_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .run   (loaded_w),
    .step  (pre_en_w),
    .limit (cfg_w.div_m1),
    .tick  (tick)
  );

  assign cfg_done = loaded_w;
endmodule

// File: rtl/fdiv_chk.sv
module fdiv_chk
  import fdiv_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int REG_ADDR = 3,
  parameter int PRE_LOG2 = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [7:0]        bus_rdata,
  input logic              tick,
  input logic              cfg_done,
  input fdiv_cfg_t         cfg
);
  localparam int GAP_W = DIV_W + PRE_LOG2 + 2;

  logic             hit;
  logic [GAP_W-1:0] gap_q;
  logic [GAP_W-1:0] ratio;

  assign hit   = (bus_addr == ADDR_W'(REG_ADDR));
  assign ratio = cfg.pre_on ? (GAP_W'(cfg.div_m1) + 1'b1) << PRE_LOG2
                            :  GAP_W'(cfg.div_m1) + 1'b1;

  // Cycles since configuring write or since last tick
  always_ff @(posedge clk) begin
    if (rst || !cfg_done) gap_q <= '0;
    else if (tick)        gap_q <= GAP_W'(1);
    else                  gap_q <= gap_q + 1'b1;
  end

  assert_tick_needs_cfg_R7: assert property (@(posedge clk) disable iff (rst)
    tick |-> cfg_done);

  assert_first_write_loads_R2: assert property (@(posedge clk) disable iff (rst)
    (hit && bus_wr && !cfg_done) |=> cfg_done);

  assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    cfg_done |=> cfg_done);

  assert_cfg_frozen_R4: assert property (@(posedge clk) disable iff (rst)
    cfg_done |=> $stable(cfg));

  assert_tick_period_R5_R6: assert property (@(posedge clk) disable iff (rst)
    tick |-> (gap_q == ratio));

  assert_readback_R3: assert property (@(posedge clk) disable iff (rst)
    $past(hit) |-> (bus_rdata == {$past(cfg_done), $past(cfg)}));

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (!cfg_done && !tick && bus_rdata == 8'h00));
endmodule

bind flash_tick_div fdiv_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .PRE_LOG2(PRE_LOG2)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rdata (bus_rdata),
  .tick      (tick),
  .cfg_done  (cfg_done),
  .cfg       (cfg_w)
);

// File: tb/sim_flash_tick_div.sv
`timescale 1ns/1ps
module sim_flash_tick_div;
  localparam int ADDR_W   = 3;
  localparam int REG_ADDR = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_wr = 1'b0;
  logic [7:0]        bus_wdata = '0;
  logic [7:0]        bus_rdata;
  logic              tick;
  logic              cfg_done;

  int    n_chk  = 0;
  int    n_fail = 0;
  int    cyc    = 0;
  int    exp_q[$];
  bit    mon_on = 1'b0;
  bit    exp_t;
  string mon_req = "R7";

  flash_tick_div #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick), .cfg_done(cfg_done)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // Monitor: pops expected tick times and compares every observed tick
  always @(negedge clk) begin
    if (mon_on) begin
      exp_t = (exp_q.size() > 0) && (exp_q[0] == cyc);
      if (exp_t) void'(exp_q.pop_front());
      if (exp_t || tick) chk(tick == exp_t, mon_req, int'(tick), int'(exp_t));
    end
  end

  task automatic do_reset();
    mon_on = 1'b0;
    exp_q.delete();
    @(negedge clk) rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [7:0] expv, input string req);
    @(negedge clk) bus_addr = a;
    @(negedge clk);
    chk(bus_rdata == expv, req, bus_rdata, expv);
  endtask

  // Driver: configuring write, then expected tick times into the queue
  task automatic start_cfg(input logic [7:0] d, input int nticks, input string req);
    int n;
    int ce;
    n = (int'(d[5:0]) + 1) * (d[6] ? 8 : 1);
    @(negedge clk);
    bus_addr = ADDR_W'(REG_ADDR); bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    #1 ce = cyc;
    for (int k = 1; k <= nticks; k++) exp_q.push_back(ce + n * k);
    mon_req = req;
    mon_on  = 1'b1;
    @(negedge clk) bus_wr = 1'b0;
  endtask

  task automatic finish_window();
    wait (exp_q.size() == 0);
    @(negedge clk);
    mon_on = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state
    chk(cfg_done == 1'b0, "R1", cfg_done, 0);
    rd(ADDR_W'(REG_ADDR), 8'h00, "R1");
    mon_req = "R1"; mon_on = 1'b1;
    repeat (20) @(negedge clk);
    mon_on = 1'b0;
    chk(tick == 1'b0, "R1", tick, 0);

    // R3: other address is ignored and reads zero
    wr(3'd5, 8'h2A);
    chk(cfg_done == 1'b0, "R3", cfg_done, 0);
    rd(3'd5, 8'h00, "R3");
    rd(ADDR_W'(REG_ADDR), 8'h00, "R3");

    // R2/R5: ratio 4; write-data bit 7 set but read-only (R3)
    start_cfg(8'h83, 6, "R5");
    chk(cfg_done == 1'b1, "R2", cfg_done, 1);
    rd(ADDR_W'(REG_ADDR), 8'h83, "R2");
    // R4: second write mid-run must change nothing
    wr(ADDR_W'(REG_ADDR), 8'h45);
    rd(ADDR_W'(REG_ADDR), 8'h83, "R4");
    finish_window();
    rd(ADDR_W'(REG_ADDR), 8'h83, "R4");

    // R8: reset stops tick and clears flag
    do_reset();
    chk(cfg_done == 1'b0, "R8", cfg_done, 0);
    mon_req = "R8"; mon_on = 1'b1;
    repeat (12) @(negedge clk);
    mon_on = 1'b0;
    rd(ADDR_W'(REG_ADDR), 8'h00, "R8");

    // R6: prescaler on, ratio 24; bit 7 clear in write data (R3)
    start_cfg(8'h42, 5, "R6");
    rd(ADDR_W'(REG_ADDR), 8'hC2, "R3");
    wr(ADDR_W'(REG_ADDR), 8'h01);
    finish_window();
    rd(ADDR_W'(REG_ADDR), 8'hC2, "R4");

    // R6: largest ratio 512
    do_reset();
    start_cfg(8'h7F, 3, "R6");
    finish_window();
    rd(ADDR_W'(REG_ADDR), 8'hFF, "R6");

    // R5/R7: ratio 1, tick every cycle
    do_reset();
    start_cfg(8'h00, 10, "R7");
    finish_window();

    // R6: prescaler with zero divide value, ratio 8
    do_reset();
    start_cfg(8'h40, 4, "R6");
    finish_window();

    // R5: largest ratio without prescaler, 64
    do_reset();
    start_cfg(8'h3F, 3, "R5");
    finish_window();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule